// File: doc/BRIEF.md
# Paged Bus Slave Register Decoder

This block sits behind the electrical layer of a parallel backplane slave and turns bus cycles into register actions for one 256-byte page. The page base comes from board switches. A cycle is taken only when its address-modifier code names one of the four accepted access types and the address falls inside that page. The code also decides whether the page base is compared over a 24-bit or a 32-bit address. The block holds the control, threshold, delay and interrupt registers, drives them out to the rest of the module, and returns read data. Reads may carry live buffer status flags or the word at the head of the output FIFO.

Some page locations are commands rather than storage. An access to one of them, read or write, issues a single-cycle pulse: a full soft reset, a switch of the buffer into full mode, or a switch into half-full mode. A read of the buffer location pops the FIFO head. Three read-only identity words at the top of the page let host software locate and recognise the board. The acknowledge is registered: it rises one cycle after a cycle is accepted and stays high until the master releases the data strobe.

Top module: `bus_page_decoder`

## Requirements
- R1: A cycle is taken only when addrStrobe and dataStrobe are both high and amCode is 0x39 or 0x3D (24-bit space) or 0x09 or 0x0D (32-bit space). Any other code gives no dtack and changes no register.
- R2: In 24-bit space only addr[23:8] is compared with baseSel[23:8], so addr[31:24] is ignored. In 32-bit space addr[31:8] is compared with baseSel[31:8]. addr[0] is ignored throughout.
- R3: dtack rises one clock after an accepted cycle. It stays high while dataStrobe is held and is low one clock after dataStrobe falls. One bus cycle performs its action exactly once.
- R4: Writes store the following. Offset 0x10 sets thrLow from data[7:0]. Offset 0x12 sets thrHigh from data[7:0]. Offset 0x14 sets delayVal from data[7:0]. Offset 0x00 sets irqLevel from data[15:13], irqOnNotEmpty from data[12] and irqStatusId from data[7:0]. Offset 0x1A sets chanEnable from data[7:0] and fastClearSel from data[15].
- R5: A read of 0x1A returns {fastClearSel, fifoEmptyN, fifoFullN, fifoHalfN, 4'b1111, chanEnable}. A read of 0x00 returns {irqLevel, irqOnNotEmpty, 4'b1111, irqStatusId}.
- R6: Any access to 0x1C, read or write, gives a one-cycle resetPulse. In that same cycle it clears chanEnable, fastClearSel, delayVal, bufModeFull, irqLevel and irqOnNotEmpty. Thresholds and irqStatusId are kept.
- R7: Any access to 0x16 sets bufModeFull and pulses modeFullPulse. Any access to 0x1E clears bufModeFull and pulses modeHalfPulse. A read of 0x14 returns {3'b000, bufModeFull, 4'b0000, delayVal}.
- R8: Reads of the identity words return 0xFAF5 at 0xFA, 0x0836 at 0xFC and the parameter ID_WORD (default 0x1001) at 0xFE. The 0xFC word is the 6-bit maker code 000010 above the 10-bit type 0000110110.
- R9: A read of 0x18 returns fifoData as sampled on the accepting edge and pulses fifoPop for one cycle. A write to 0x18 pops nothing.
- R10: A read of an unmapped offset, of the write-only threshold offsets 0x10 and 0x12, or of the command offsets 0x16, 0x1C and 0x1E returns 0xFFFF and is still acknowledged.
- R11: At most one of resetPulse, modeFullPulse, modeHalfPulse and fifoPop is high in any cycle. Each lasts one cycle and coincides with dtack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baseSel | input | 32 | Switch-set page base; bits 7..0 unused |
| addr | input | 32 | Bus address |
| amCode | input | 6 | Address-modifier code |
| addrStrobe | input | 1 | Address strobe, active high |
| dataStrobe | input | 1 | Data strobe, active high |
| writeEn | input | 1 | 1 = write cycle, 0 = read cycle |
| wrData | input | 16 | Write data |
| fifoData | input | 16 | Word at the head of the output FIFO |
| fifoEmptyN | input | 1 | Low when the FIFO is empty |
| fifoFullN | input | 1 | Low when the FIFO is full |
| fifoHalfN | input | 1 | Low when the FIFO is half full |
| dtack | output | 1 | Data acknowledge |
| rdData | output | 16 | Read data, valid while dtack is high |
| resetPulse | output | 1 | One-cycle soft reset command |
| modeFullPulse | output | 1 | One-cycle full-mode select command |
| modeHalfPulse | output | 1 | One-cycle half-full-mode select command |
| fifoPop | output | 1 | One-cycle FIFO pop |
| chanEnable | output | 8 | Channel enables |
| fastClearSel | output | 1 | Fast-clear select |
| thrLow | output | 8 | Low threshold |
| thrHigh | output | 8 | High threshold |
| delayVal | output | 8 | Conversion delay setting |
| bufModeFull | output | 1 | Buffer mode: 1 full, 0 half-full |
| irqLevel | output | 3 | Interrupt level |
| irqOnNotEmpty | output | 1 | Interrupt condition: 1 not-empty, 0 half-full |
| irqStatusId | output | 8 | Interrupt vector |

## Verification
The assertions assume a well-behaved master. Once it raises the data strobe, it keeps the address, modifier and write flag steady until it sees the acknowledge, and it drops the data strobe before it starts another cycle. The pulse checks also rely on this: a new cycle can begin only after the handshake has gone back to idle. The bench's access task follows this discipline. It drives on the falling clock edge, waits for the acknowledge before releasing, and always spends one idle cycle between accesses. The rejection tests hold the strobes for several cycles and then let go without an acknowledge.

// File: rtl/bus_page_pkg.sv
package bus_page_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 32;

  localparam logic [7:0] OFS_IRQ    = 8'h00;
  localparam logic [7:0] OFS_THR_LO = 8'h10;
  localparam logic [7:0] OFS_THR_HI = 8'h12;
  localparam logic [7:0] OFS_DELAY  = 8'h14;
  localparam logic [7:0] OFS_FULL   = 8'h16;
  localparam logic [7:0] OFS_BUF    = 8'h18;
  localparam logic [7:0] OFS_CTRL   = 8'h1A;
  localparam logic [7:0] OFS_RESET  = 8'h1C;
  localparam logic [7:0] OFS_HALF   = 8'h1E;
  localparam logic [7:0] OFS_ID_FIX = 8'hFA;
  localparam logic [7:0] OFS_ID_TYP = 8'hFC;
  localparam logic [7:0] OFS_ID_VER = 8'hFE;

  localparam logic [15:0] ID_FIXED = 16'hFAF5;
  localparam logic [5:0]  MAKER    = 6'b000010;
  localparam logic [9:0]  BOARD    = 10'b0000110110;

  typedef struct packed {
    logic       capture;
    logic [7:0] offset;
    logic       wrIrq;
    logic       wrThrLo;
    logic       wrThrHi;
    logic       wrDelay;
    logic       wrCtrl;
    logic       doReset;
    logic       selFull;
    logic       selHalf;
    logic       popFifo;
  } accStb_t;
endpackage

// File: rtl/bus_page_ctrl.sv
module bus_page_ctrl
  import bus_page_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] baseSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [5:0]        amCode,
  input  logic              addrStrobe,
  input  logic              dataStrobe,
  input  logic              writeEn,
  output accStb_t           stb,
  output logic              dtack
);
  typedef enum logic {ST_IDLE, ST_ACK} state_t;
  state_t state;

  logic isShort, isLong, baseHit, accept;
  logic [7:0] ofs;

  always_comb begin
    isShort = (amCode == 6'h39) || (amCode == 6'h3D);
    isLong  = (amCode == 6'h09) || (amCode == 6'h0D);
    baseHit = (isShort && addr[23:8] == baseSel[23:8]) ||
              (isLong  && addr[31:8] == baseSel[31:8]);
    accept  = (state == ST_IDLE) && addrStrobe && dataStrobe && baseHit;
    ofs     = {addr[7:1], 1'b0};
  end

  always_comb begin
    stb          = '0;
    stb.capture  = accept;
    stb.offset   = ofs;
    stb.wrIrq    = accept && writeEn && ofs == OFS_IRQ;
    stb.wrThrLo  = accept && writeEn && ofs == OFS_THR_LO;
    stb.wrThrHi  = accept && writeEn && ofs == OFS_THR_HI;
    stb.wrDelay  = accept && writeEn && ofs == OFS_DELAY;
    stb.wrCtrl   = accept && writeEn && ofs == OFS_CTRL;
    stb.doReset  = accept && ofs == OFS_RESET;
    stb.selFull  = accept && ofs == OFS_FULL;
    stb.selHalf  = accept && ofs == OFS_HALF;
    stb.popFifo  = accept && !writeEn && ofs == OFS_BUF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (accept) state <= ST_ACK;
        ST_ACK:  if (!dataStrobe) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dtack = (state == ST_ACK);
endmodule

// File: rtl/bus_page_regs.sv
module bus_page_regs
  import bus_page_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_WORD = 16'h1001
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStb_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              fifoEmptyN,
  input  logic              fifoFullN,
  input  logic              fifoHalfN,
  output logic [DATA_W-1:0] rdData,
  output logic              resetPulse,
  output logic              modeFullPulse,
  output logic              modeHalfPulse,
  output logic              fifoPop,
  output logic [7:0]        chanEnable,
  output logic              fastClearSel,
  output logic [7:0]        thrLow,
  output logic [7:0]        thrHigh,
  output logic [7:0]        delayVal,
  output logic              bufModeFull,
  output logic [2:0]        irqLevel,
  output logic              irqOnNotEmpty,
  output logic [7:0]        irqStatusId
);
  logic [DATA_W-1:0] readMux;

  always_comb begin
    case (stb.offset)
      OFS_IRQ:    readMux = {irqLevel, irqOnNotEmpty, 4'hF, irqStatusId};
      OFS_DELAY:  readMux = {3'b000, bufModeFull, 4'h0, delayVal};
      OFS_BUF:    readMux = fifoData;
      OFS_CTRL:   readMux = {fastClearSel, fifoEmptyN, fifoFullN, fifoHalfN, 4'hF, chanEnable};
      OFS_ID_FIX: readMux = ID_FIXED;
      OFS_ID_TYP: readMux = {MAKER, BOARD};
      OFS_ID_VER: readMux = ID_WORD;
      default:    readMux = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData        <= '1;
      resetPulse    <= 1'b0;
      modeFullPulse <= 1'b0;
      modeHalfPulse <= 1'b0;
      fifoPop       <= 1'b0;
      chanEnable    <= '0;
      fastClearSel  <= 1'b0;
      thrLow        <= '0;
      thrHigh       <= '0;
      delayVal      <= '0;
      bufModeFull   <= 1'b0;
      irqLevel      <= '0;
      irqOnNotEmpty <= 1'b0;
      irqStatusId   <= '0;
    end else begin
      resetPulse    <= stb.doReset;
      modeFullPulse <= stb.selFull;
      modeHalfPulse <= stb.selHalf;
      fifoPop       <= stb.popFifo;
      if (stb.capture) rdData <= readMux;
      if (stb.wrThrLo) thrLow  <= wrData[7:0];
      if (stb.wrThrHi) thrHigh <= wrData[7:0];
      if (stb.wrDelay) delayVal <= wrData[7:0];
      if (stb.wrCtrl) begin
        chanEnable   <= wrData[7:0];
        fastClearSel <= wrData[15];
      end
      if (stb.wrIrq) begin
        irqLevel      <= wrData[15:13];
        irqOnNotEmpty <= wrData[12];
        irqStatusId   <= wrData[7:0];
      end
      if (stb.selFull) bufModeFull <= 1'b1;
      if (stb.selHalf) bufModeFull <= 1'b0;
      if (stb.doReset) begin
        chanEnable    <= '0;
        fastClearSel  <= 1'b0;
        delayVal      <= '0;
        bufModeFull   <= 1'b0;
        irqLevel      <= '0;
        irqOnNotEmpty <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bus_page_decoder.sv
module bus_page_decoder
  import bus_page_pkg::*;
#(
  parameter logic [15:0] ID_WORD = 16'h1001
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] baseSel,
  input  logic [31:0] addr,
  input  logic [5:0]  amCode,
  input  logic        addrStrobe,
  input  logic        dataStrobe,
  input  logic        writeEn,
  input  logic [15:0] wrData,
  input  logic [15:0] fifoData,
  input  logic        fifoEmptyN,
  input  logic        fifoFullN,
  input  logic        fifoHalfN,
  output logic        dtack,
  output logic [15:0] rdData,
  output logic        resetPulse,
  output logic        modeFullPulse,
  output logic        modeHalfPulse,
  output logic        fifoPop,
  output logic [7:0]  chanEnable,
  output logic        fastClearSel,
  output logic [7:0]  thrLow,
  output logic [7:0]  thrHigh,
  output logic [7:0]  delayVal,
  output logic        bufModeFull,
  output logic [2:0]  irqLevel,
  output logic        irqOnNotEmpty,
  output logic [7:0]  irqStatusId
);
  accStb_t stb;

  bus_page_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .baseSel(baseSel), .addr(addr), .amCode(amCode),
    .addrStrobe(addrStrobe), .dataStrobe(dataStrobe), .writeEn(writeEn),
    .stb(stb), .dtack(dtack)
  );

  bus_page_regs #(.ID_WORD(ID_WORD)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .fifoData(fifoData),
    .fifoEmptyN(fifoEmptyN), .fifoFullN(fifoFullN), .fifoHalfN(fifoHalfN),
    .rdData(rdData), .resetPulse(resetPulse), .modeFullPulse(modeFullPulse),
    .modeHalfPulse(modeHalfPulse), .fifoPop(fifoPop), .chanEnable(chanEnable),
    .fastClearSel(fastClearSel), .thrLow(thrLow), .thrHigh(thrHigh),
    .delayVal(delayVal), .bufModeFull(bufModeFull), .irqLevel(irqLevel),
    .irqOnNotEmpty(irqOnNotEmpty), .irqStatusId(irqStatusId)
  );
endmodule

// File: rtl/bus_page_checker.sv
module bus_page_checker (
  input logic       clk,
  input logic       rstN,
  input logic       addrStrobe,
  input logic       dataStrobe,
  input logic       dtack,
  input logic       resetPulse,
  input logic       modeFullPulse,
  input logic       modeHalfPulse,
  input logic       fifoPop,
  input logic [7:0] chanEnable,
  input logic       fastClearSel,
  input logic       bufModeFull
);
  // R3: acknowledge only follows a cycle with both strobes high
  p_ack_after_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dtack) |-> $past(addrStrobe && dataStrobe));

  // R3: acknowledge drops once the data strobe is released
  p_ack_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dtack && !dataStrobe) |=> !dtack);

  // R11: side-effect pulses are mutually exclusive
  p_pulse_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resetPulse, modeFullPulse, modeHalfPulse, fifoPop}));

  // R11: every pulse coincides with the acknowledge
  p_pulse_with_ack_r11: assert property (@(posedge clk) disable iff (!rstN)
    (resetPulse || modeFullPulse || modeHalfPulse || fifoPop) |-> dtack);

  // R9: a pop lasts one cycle
  p_pop_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> !fifoPop);

  // R6: soft reset leaves enables and fast-clear cleared
  p_reset_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    resetPulse |-> (chanEnable == 8'h00 && !fastClearSel && !bufModeFull));

  // R7: the mode follows its select pulses
  p_mode_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    modeFullPulse |-> bufModeFull);
  p_mode_half_r7: assert property (@(posedge clk) disable iff (!rstN)
    modeHalfPulse |-> !bufModeFull);
endmodule

bind bus_page_decoder bus_page_checker u_chk (
  .clk(clk), .rstN(rstN), .addrStrobe(addrStrobe), .dataStrobe(dataStrobe),
  .dtack(dtack), .resetPulse(resetPulse), .modeFullPulse(modeFullPulse),
  .modeHalfPulse(modeHalfPulse), .fifoPop(fifoPop), .chanEnable(chanEnable),
  .fastClearSel(fastClearSel), .bufModeFull(bufModeFull)
);

// File: tb/bus_page_decoder_tb.sv
`timescale 1ns/1ps
module bus_page_decoder_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] baseSel = 32'h1234_5600;
  logic [31:0] addr = '0;
  logic [5:0]  amCode = '0;
  logic addrStrobe = 1'b0, dataStrobe = 1'b0, writeEn = 1'b0;
  logic [15:0] wrData = '0, fifoData = 16'h0000;
  logic fifoEmptyN = 1'b1, fifoFullN = 1'b1, fifoHalfN = 1'b0;
  logic dtack, resetPulse, modeFullPulse, modeHalfPulse, fifoPop;
  logic fastClearSel, bufModeFull, irqOnNotEmpty;
  logic [15:0] rdData;
  logic [7:0] chanEnable, thrLow, thrHigh, delayVal, irqStatusId;
  logic [2:0] irqLevel;

  int nRun = 0, nFail = 0;
  logic acked, sawReset, sawFull, sawHalf, sawPop;
  logic [15:0] rdVal;

  localparam logic [5:0] AM_S = 6'h39, AM_S2 = 6'h3D, AM_L = 6'h09, AM_L2 = 6'h0D;

  always #5 clk = ~clk;

  bus_page_decoder u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle; samples ack, data and pulses at the first negedge with dtack
  task automatic access(input logic [5:0] am, input logic [31:0] a, input logic wr,
                        input logic [15:0] d, input int hold);
    acked = 0; sawReset = 0; sawFull = 0; sawHalf = 0; sawPop = 0; rdVal = 'x;
    @(negedge clk);
    amCode = am; addr = a; writeEn = wr; wrData = d;
    addrStrobe = 1; dataStrobe = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (dtack) begin
        acked = 1; rdVal = rdData;
        sawReset = resetPulse; sawFull = modeFullPulse;
        sawHalf = modeHalfPulse; sawPop = fifoPop;
        break;
      end
    end
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R3 held", dtack, 1'b1);
      check("R11 single", {resetPulse, modeFullPulse, modeHalfPulse, fifoPop}, 4'b0);
    end
    addrStrobe = 0; dataStrobe = 0;
    @(negedge clk);
    check("R3 drop", dtack, 1'b0);
  endtask

  task automatic t_reset_state;
    check("reset dtack", dtack, 0);
    check("reset chanEnable", chanEnable, 0);
    check("reset mode", bufModeFull, 0);
  endtask

  task automatic t_am_filter;
    access(6'h3F, 32'h0034_5610, 1, 16'h0055, 0);
    check("R1 bad am no ack", acked, 0);
    check("R1 bad am no write", thrLow, 8'h00);
    access(AM_S2, 32'h0034_5610, 1, 16'h0011, 0);
    check("R1 am 3D ack", acked, 1);
    check("R4 thrLow", thrLow, 8'h11);
    access(AM_L2, 32'h1234_5612, 1, 16'hFF22, 0);
    check("R1 am 0D ack", acked, 1);
    check("R4 thrHigh", thrHigh, 8'h22);
  endtask

  task automatic t_base;
    access(AM_S, 32'hAB34_5610, 1, 16'h0033, 0);
    check("R2 short ignores top byte", thrLow, 8'h33);
    access(AM_L, 32'hAB34_5610, 1, 16'h0044, 0);
    check("R2 long compares top byte", acked, 0);
    check("R2 long miss keeps", thrLow, 8'h33);
    access(AM_S, 32'h0034_5710, 1, 16'h0066, 0);
    check("R2 page miss", acked, 0);
    access(AM_L, 32'h1234_5611, 1, 16'h0077, 0);
    check("R2 addr0 ignored", thrLow, 8'h77);
  endtask

  task automatic t_regs;
    access(AM_L, 32'h1234_561A, 1, 16'h8FA5, 2);
    check("R4 chanEnable", chanEnable, 8'hA5);
    check("R4 fastClear", fastClearSel, 1);
    access(AM_L, 32'h1234_561A, 0, 0, 0);
    check("R5 control read", rdVal, 16'hEFA5);
    access(AM_L, 32'h1234_5600, 1, 16'hB3C7, 0);
    check("R4 irq fields", {irqLevel, irqOnNotEmpty, irqStatusId}, {3'b101, 1'b1, 8'hC7});
    access(AM_L, 32'h1234_5600, 0, 0, 0);
    check("R5 irq read", rdVal, 16'hBFC7);
    access(AM_L, 32'h1234_5614, 1, 16'hFF42, 0);
    check("R4 delay", delayVal, 8'h42);
  endtask

  task automatic t_mode;
    access(AM_L, 32'h1234_5616, 0, 0, 0);
    check("R7 full read pulse", sawFull, 1);
    check("R7 full mode", bufModeFull, 1);
    check("R10 cmd read ones", rdVal, 16'hFFFF);
    access(AM_L, 32'h1234_5614, 0, 0, 0);
    check("R7 delay read full", rdVal, 16'h1042);
    access(AM_L, 32'h1234_561E, 1, 16'h0000, 0);
    check("R7 half write pulse", sawHalf, 1);
    check("R7 half mode", bufModeFull, 0);
    access(AM_L, 32'h1234_5614, 0, 0, 0);
    check("R7 delay read half", rdVal, 16'h0042);
    access(AM_L, 32'h1234_5616, 1, 16'h0000, 0);
    check("R7 full write", bufModeFull, 1);
  endtask

  task automatic t_soft_reset;
    access(AM_S, 32'h0034_561C, 0, 0, 1);
    check("R6 read pulse", sawReset, 1);
    check("R6 enables", chanEnable, 8'h00);
    check("R6 fastClear", fastClearSel, 0);
    check("R6 delay", delayVal, 8'h00);
    check("R6 mode", bufModeFull, 0);
    check("R6 irq", {irqLevel, irqOnNotEmpty, irqStatusId}, {3'b000, 1'b0, 8'hC7});
    check("R6 thresholds kept", {thrLow, thrHigh}, 16'h7722);
    access(AM_L, 32'h1234_561A, 0, 0, 0);
    check("R5 control after reset", rdVal, 16'h6F00);
    access(AM_L, 32'h1234_561A, 1, 16'h0003, 0);
    access(AM_L, 32'h1234_561C, 1, 16'h0000, 0);
    check("R6 write pulse", sawReset, 1);
    check("R6 write clears", chanEnable, 8'h00);
  endtask

  task automatic t_fifo;
    fifoData = 16'h8123;
    access(AM_L, 32'h1234_5618, 0, 0, 2);
    check("R9 data", rdVal, 16'h8123);
    check("R9 pop", sawPop, 1);
    fifoData = 16'h0456;
    access(AM_L, 32'h1234_5618, 1, 16'h1111, 0);
    check("R9 write no pop", sawPop, 0);
    check("R11 no other pulse", {sawReset, sawFull, sawHalf}, 3'b000);
  endtask

  task automatic t_ident;
    access(AM_L, 32'h1234_56FA, 0, 0, 0);
    check("R8 fixed", rdVal, 16'hFAF5);
    access(AM_L, 32'h1234_56FC, 0, 0, 0);
    check("R8 type", rdVal, 16'h0836);
    access(AM_S, 32'h0034_56FE, 0, 0, 0);
    check("R8 version", rdVal, 16'h1001);
    access(AM_L, 32'h1234_5640, 0, 0, 0);
    check("R10 unmapped ack", acked, 1);
    check("R10 unmapped ones", rdVal, 16'hFFFF);
    access(AM_L, 32'h1234_5610, 0, 0, 0);
    check("R10 write-only ones", rdVal, 16'hFFFF);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1;
        @(negedge clk);
        t_reset_state();
        t_am_filter();
        t_base();
        t_regs();
        t_mode();
        t_soft_reset();
        t_fifo();
        t_ident();
      end
      begin
        repeat (20000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule